// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block keeps the interrupt context of a single hardware thread. Incoming interrupts arrive with a priority and a flag that marks them as either aimed at this thread directly or offered to a group of threads. Directly aimed interrupts are recorded in a pending-priority bitmap. A group interrupt is held in one slot, and only while it is the one being signalled. The block works out the posted priority and drives a notification status byte and an interrupt line toward the thread. Software can raise or lower the thread's current priority threshold, acknowledge the signalled interrupt, or pull the whole context off the thread.

Priorities are 3-bit values, and 0 is the most favoured. The posted priority and the threshold are byte-wide, and 0xFF in them stands for "none". The block never silently drops a group interrupt. If a group interrupt cannot be signalled, or stops being signalled before software acknowledges it, the block sends its priority out on a one-cycle redistribute request, so another thread can take it. Only one strobe takes effect per cycle. A pull beats an acknowledge, an acknowledge beats a threshold write, and a threshold write beats a presentation.

Top module: `thread_prio_presenter`

## Requirements
- R1: A direct presentation (group flag 0) of priority p always sets bit p of the pending bitmap, whatever priority is currently posted.
- R2: A presentation of priority p is signalled only if p is numerically lower than the posted priority (not the threshold). The posted priority then becomes p one cycle later, the status byte becomes 0x80 for a direct interrupt or 0xC0 for a group one, and the irq line rises. Otherwise the posted priority and the status byte are left unchanged. irq is high exactly when the status byte is non-zero.
- R3: A group presentation that is not signalled produces a one-cycle redistribute request carrying its priority. A signalled group interrupt that is displaced by a more favoured presentation produces the same request for its own priority.
- R4: A threshold write of value c sets the threshold to c. It sets the posted priority to the smaller of c and the most favoured pending priority, and the interrupt is signalled only if that result is below c. The posted priority is never numerically above the threshold.
- R5: A threshold write that precludes the signalled interrupt clears the status byte and lowers irq. If that interrupt was a group interrupt, it is dropped from the context and a redistribute request with its priority is issued.
- R6: An acknowledge while the status byte is non-zero clears the whole byte in one cycle. It sets both the threshold and the posted priority to the acknowledged priority, and it removes the source: the group slot, or the bitmap bit for a direct interrupt. An acknowledge while the status byte is zero changes nothing.
- R7: A pull outputs, for one cycle, the pre-pull state packed as {status[31:24], threshold[23:16], posted[15:8], bitmap[7:0]}. It returns the context to its reset state with irq low, and it redistributes a held group interrupt.
- R8: After reset the status byte is 0, irq is low, the threshold and the posted priority are 0xFF, and the bitmap is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pres_valid | input | 1 | Present a new interrupt this cycle |
| pres_prio | input | PRIO_W | Priority of the presented interrupt |
| pres_group | input | 1 | 1 = group interrupt, 0 = direct |
| cppr_we | input | 1 | Write the current threshold |
| cppr_wdata | input | 8 | New threshold value |
| ack | input | 1 | Acknowledge the signalled interrupt |
| pull | input | 1 | Pull the context off the thread |
| irq | output | 1 | Interrupt line toward the thread |
| nsr_o | output | 8 | Status byte: bit 7 signalled, bit 6 group |
| pipr_o | output | 8 | Posted priority |
| cppr_o | output | 8 | Current threshold |
| ipb_o | output | 2**PRIO_W | Pending direct-priority bitmap |
| redist_valid | output | 1 | Redistribute request pulse |
| redist_prio | output | PRIO_W | Priority of the redistributed group interrupt |
| pull_valid | output | 1 | Pull snapshot valid pulse |
| pull_data | output | 32 | Pre-pull context snapshot |

## Verification
Presentations are sent in with priorities above, equal to and below the posted value, and with the threshold set looser than the posted priority. This shows whether the preemption decision uses the posted priority or the threshold: a group interrupt at priority 3 is sent while 2 is posted and the threshold is 6, and it must be redistributed rather than signalled. Threshold writes are tried in four ways: loosening, tightening to exactly the posted priority, tightening below a signalled group interrupt, and loosening again so a pending direct bit reappears. Together these separate clamping, preclusion and redistribution. Acknowledge is issued with and without a signalled interrupt, and a pull is made with a group interrupt held, to check the snapshot contents and the returned request.

// File: rtl/tipp_pkg.sv
package tipp_pkg;
    localparam int PREG_W = 8;
    typedef logic [PREG_W-1:0] preg_t;
    localparam preg_t PRIO_NONE = '1;

    typedef struct packed {
        logic       sig;
        logic       grp;
        logic [5:0] rsvd;
    } nsr_t;

    typedef struct packed {
        nsr_t  nsr;
        preg_t cppr;
        preg_t pipr;
        preg_t ipb;
    } snap_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PRESENT,
        OP_CPPR,
        OP_ACK,
        OP_PULL
    } op_e;

    function automatic preg_t pmin(preg_t a, preg_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic op_e pick_op(logic pl, logic ak, logic cw, logic pv);
        if (pl)      return OP_PULL;
        else if (ak) return OP_ACK;
        else if (cw) return OP_CPPR;
        else if (pv) return OP_PRESENT;
        return OP_IDLE;
    endfunction
endpackage

// File: rtl/tipp_prio_enc.sv
module tipp_prio_enc
    import tipp_pkg::*;
#(
    parameter int NPRIO = 8
) (
    input  logic [NPRIO-1:0] bits,
    output preg_t            best
);
    always_comb begin
        best = PRIO_NONE;
        for (int i = NPRIO - 1; i >= 0; i--) begin
            if (bits[i]) best = preg_t'(i);
        end
    end
endmodule

// File: rtl/tipp_pull_snap.sv
module tipp_pull_snap
    import tipp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        capture,
    input  snap_t       state_in,
    output logic [31:0] data,
    output logic        valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) data <= state_in;
        end
    end
endmodule

// File: rtl/thread_prio_presenter.sv
module thread_prio_presenter
    import tipp_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pres_valid,
    input  logic [PRIO_W-1:0]      pres_prio,
    input  logic                   pres_group,
    input  logic                   cppr_we,
    input  logic [7:0]             cppr_wdata,
    input  logic                   ack,
    input  logic                   pull,
    output logic                   irq,
    output logic [7:0]             nsr_o,
    output logic [7:0]             pipr_o,
    output logic [7:0]             cppr_o,
    output logic [(1<<PRIO_W)-1:0] ipb_o,
    output logic                   redist_valid,
    output logic [PRIO_W-1:0]      redist_prio,
    output logic                   pull_valid,
    output logic [31:0]            pull_data
);
    localparam int NPRIO = 1 << PRIO_W;

    logic [NPRIO-1:0]  ipb_q, ipb_n;
    preg_t             cppr_q, cppr_n, pipr_q, pipr_n;
    nsr_t              nsr_q, nsr_n;
    logic              grp_v_q, grp_v_n;
    logic [PRIO_W-1:0] grp_p_q, grp_p_n;
    logic              rd_v_n;
    logic [PRIO_W-1:0] rd_p_n;

    preg_t ipb_best;
    op_e   op;
    preg_t pres_w, grp_w, best_all;
    logic  take, keep_grp, sig_w;
    snap_t snap;

    tipp_prio_enc #(.NPRIO(NPRIO)) u_enc (
        .bits (ipb_q),
        .best (ipb_best)
    );

    assign op     = pick_op(pull, ack, cppr_we, pres_valid);
    assign pres_w = preg_t'(pres_prio);
    assign grp_w  = preg_t'(grp_p_q);
    assign snap   = '{nsr: nsr_q, cppr: cppr_q, pipr: pipr_q, ipb: preg_t'(ipb_q)};

    always_comb begin
        ipb_n    = ipb_q;
        cppr_n   = cppr_q;
        pipr_n   = pipr_q;
        nsr_n    = nsr_q;
        grp_v_n  = grp_v_q;
        grp_p_n  = grp_p_q;
        rd_v_n   = 1'b0;
        rd_p_n   = grp_p_q;
        take     = pres_w < pipr_q;
        keep_grp = grp_v_q && (grp_w < cppr_wdata);
        best_all = pmin(ipb_best, keep_grp ? grp_w : PRIO_NONE);
        sig_w    = 1'b0;
        unique case (op)
            OP_PRESENT: begin
                if (!pres_group) ipb_n[pres_prio] = 1'b1;
                if (take) begin
                    pipr_n = pres_w;
                    nsr_n  = '{sig: 1'b1, grp: pres_group, rsvd: '0};
                    if (grp_v_q) rd_v_n = 1'b1;
                    grp_v_n = pres_group;
                    if (pres_group) grp_p_n = pres_prio;
                end else if (pres_group) begin
                    rd_v_n = 1'b1;
                    rd_p_n = pres_prio;
                end
            end
            OP_CPPR: begin
                if (grp_v_q && !keep_grp) rd_v_n = 1'b1;
                grp_v_n = keep_grp;
                cppr_n  = cppr_wdata;
                pipr_n  = pmin(best_all, cppr_wdata);
                sig_w   = pipr_n < cppr_wdata;
                nsr_n   = '{sig: sig_w, grp: sig_w && keep_grp && (grp_w == pipr_n), rsvd: '0};
            end
            OP_ACK: begin
                if (nsr_q.sig) begin
                    cppr_n = pipr_q;
                    if (nsr_q.grp) grp_v_n = 1'b0;
                    else           ipb_n[pipr_q[PRIO_W-1:0]] = 1'b0;
                end
                nsr_n = '0;
            end
            OP_PULL: begin
                if (grp_v_q) rd_v_n = 1'b1;
                ipb_n   = '0;
                cppr_n  = PRIO_NONE;
                pipr_n  = PRIO_NONE;
                nsr_n   = '0;
                grp_v_n = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ipb_q        <= '0;
            cppr_q       <= PRIO_NONE;
            pipr_q       <= PRIO_NONE;
            nsr_q        <= '0;
            grp_v_q      <= 1'b0;
            grp_p_q      <= '0;
            redist_valid <= 1'b0;
            redist_prio  <= '0;
        end else begin
            ipb_q        <= ipb_n;
            cppr_q       <= cppr_n;
            pipr_q       <= pipr_n;
            nsr_q        <= nsr_n;
            grp_v_q      <= grp_v_n;
            grp_p_q      <= grp_p_n;
            redist_valid <= rd_v_n;
            redist_prio  <= rd_p_n;
        end
    end

    tipp_pull_snap u_snap (
        .clk      (clk),
        .rst      (rst),
        .capture  (op == OP_PULL),
        .state_in (snap),
        .data     (pull_data),
        .valid    (pull_valid)
    );

    assign irq    = |nsr_q;
    assign nsr_o  = nsr_q;
    assign pipr_o = pipr_q;
    assign cppr_o = cppr_q;
    assign ipb_o  = ipb_q;
endmodule

// File: rtl/tipp_checker.sv
module tipp_checker #(
    parameter int PRIO_W = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   pres_valid,
    input logic [PRIO_W-1:0]      pres_prio,
    input logic                   pres_group,
    input logic                   cppr_we,
    input logic                   ack,
    input logic                   pull,
    input logic                   irq,
    input logic [7:0]             nsr_o,
    input logic [7:0]             pipr_o,
    input logic [7:0]             cppr_o,
    input logic [(1<<PRIO_W)-1:0] ipb_o,
    input logic                   redist_valid,
    input logic [PRIO_W-1:0]      redist_prio,
    input logic                   pull_valid
);
    logic       only_pres;
    logic [7:0] pres_ext;
    assign only_pres = pres_valid && !cppr_we && !ack && !pull;
    assign pres_ext  = {{(8-PRIO_W){1'b0}}, pres_prio};

    assert_pipr_bound_R4: assert property (@(posedge clk) disable iff (rst)
        pipr_o <= cppr_o);

    assert_direct_ipb_R1: assert property (@(posedge clk) disable iff (rst)
        only_pres && !pres_group |=> ipb_o[$past(pres_prio)]);

    assert_no_preempt_R2: assert property (@(posedge clk) disable iff (rst)
        only_pres && (pres_ext >= pipr_o) |=> $stable(pipr_o) && $stable(nsr_o));

    assert_grp_redist_R3: assert property (@(posedge clk) disable iff (rst)
        only_pres && pres_group && (pres_ext >= pipr_o)
        |=> redist_valid && (redist_prio == $past(pres_prio)));

    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ack && !pull |=> nsr_o == 8'h00);

    assert_pull_reset_R7: assert property (@(posedge clk) disable iff (rst)
        pull |=> !irq && pull_valid && (cppr_o == 8'hFF));
endmodule

bind thread_prio_presenter tipp_checker #(.PRIO_W(PRIO_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pres_valid   (pres_valid),
    .pres_prio    (pres_prio),
    .pres_group   (pres_group),
    .cppr_we      (cppr_we),
    .ack          (ack),
    .pull         (pull),
    .irq          (irq),
    .nsr_o        (nsr_o),
    .pipr_o       (pipr_o),
    .cppr_o       (cppr_o),
    .ipb_o        (ipb_o),
    .redist_valid (redist_valid),
    .redist_prio  (redist_prio),
    .pull_valid   (pull_valid)
);

// File: tb/sim_thread_prio_presenter.sv
`timescale 1ns/1ps
module sim_thread_prio_presenter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pres_valid = 1'b0;
    logic [2:0]  pres_prio = '0;
    logic        pres_group = 1'b0;
    logic        cppr_we = 1'b0;
    logic [7:0]  cppr_wdata = '0;
    logic        ack = 1'b0;
    logic        pull = 1'b0;
    logic        irq;
    logic [7:0]  nsr_o, pipr_o, cppr_o, ipb_o;
    logic        redist_valid, pull_valid;
    logic [2:0]  redist_prio;
    logic [31:0] pull_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [7:0]  nsr, cppr, pipr, ipb;
        logic        rv;
        logic [2:0]  rp;
        logic        pv;
        logic [31:0] pd;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    thread_prio_presenter #(.PRIO_W(3)) u0 (
        .clk(clk), .rst(rst), .pres_valid(pres_valid), .pres_prio(pres_prio),
        .pres_group(pres_group), .cppr_we(cppr_we), .cppr_wdata(cppr_wdata),
        .ack(ack), .pull(pull), .irq(irq), .nsr_o(nsr_o), .pipr_o(pipr_o),
        .cppr_o(cppr_o), .ipb_o(ipb_o), .redist_valid(redist_valid),
        .redist_prio(redist_prio), .pull_valid(pull_valid), .pull_data(pull_data)
    );

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.tag, "nsr",  {24'h0, nsr_o},  {24'h0, e.nsr});
            cmp(e.tag, "cppr", {24'h0, cppr_o}, {24'h0, e.cppr});
            cmp(e.tag, "pipr", {24'h0, pipr_o}, {24'h0, e.pipr});
            cmp(e.tag, "ipb",  {24'h0, ipb_o},  {24'h0, e.ipb});
            cmp(e.tag, "irq",  {31'h0, irq},    {31'h0, (e.nsr != 8'h00)});
            cmp(e.tag, "redist_valid", {31'h0, redist_valid}, {31'h0, e.rv});
            if (e.rv) cmp(e.tag, "redist_prio", {29'h0, redist_prio}, {29'h0, e.rp});
            cmp(e.tag, "pull_valid", {31'h0, pull_valid}, {31'h0, e.pv});
            if (e.pv) cmp(e.tag, "pull_data", pull_data, e.pd);
        end
    end

    task automatic push(input string tag, input logic [7:0] en, ec, ep, ei,
                        input logic erv, input logic [2:0] erp,
                        input logic epv, input logic [31:0] epd);
        exp_t e;
        e.tag = tag; e.nsr = en; e.cppr = ec; e.pipr = ep; e.ipb = ei;
        e.rv = erv; e.rp = erp; e.pv = epv; e.pd = epd;
        sb.push_back(e);
    endtask

    // driver: one operation per cycle, then the expected state is queued
    task automatic step(input string tag, input logic pv_i, input logic [2:0] pp, input logic pg,
                        input logic cw, input logic [7:0] cd, input logic ak, input logic pl,
                        input logic [7:0] en, ec, ep, ei, input logic erv, input logic [2:0] erp,
                        input logic epv, input logic [31:0] epd);
        @(negedge clk);
        pres_valid = pv_i; pres_prio = pp; pres_group = pg;
        cppr_we = cw; cppr_wdata = cd; ack = ak; pull = pl;
        @(posedge clk);
        #1;
        pres_valid = 1'b0; cppr_we = 1'b0; ack = 1'b0; pull = 1'b0;
        push(tag, en, ec, ep, ei, erv, erp, epv, epd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push("R8 reset", 8'h00, 8'hFF, 8'hFF, 8'h00, 0, 0, 0, 0);
        //     tag                         pv p  g  cw cd     ak pl  nsr    cppr   pipr   ipb    rv rp pv pd
        step("R1 R2 direct 2 presented",   1, 2, 0, 0, 8'h00, 0, 0, 8'h80, 8'hFF, 8'h02, 8'h04, 0, 0, 0, 0);
        step("R1 R2 direct 5 held only",   1, 5, 0, 0, 8'h00, 0, 0, 8'h80, 8'hFF, 8'h02, 8'h24, 0, 0, 0, 0);
        step("R3 group 4 rejected",        1, 4, 1, 0, 8'h00, 0, 0, 8'h80, 8'hFF, 8'h02, 8'h24, 1, 4, 0, 0);
        step("R2 group 1 presented",       1, 1, 1, 0, 8'h00, 0, 0, 8'hC0, 8'hFF, 8'h01, 8'h24, 0, 0, 0, 0);
        step("R3 group 1 displaced",       1, 0, 0, 0, 8'h00, 0, 0, 8'h80, 8'hFF, 8'h00, 8'h25, 1, 1, 0, 0);
        step("R6 ack direct 0",            0, 0, 0, 0, 8'h00, 1, 0, 8'h00, 8'h00, 8'h00, 8'h24, 0, 0, 0, 0);
        step("R4 cppr FF reposts 2",       0, 0, 0, 1, 8'hFF, 0, 0, 8'h80, 8'hFF, 8'h02, 8'h24, 0, 0, 0, 0);
        step("R4 cppr 3 keeps 2",          0, 0, 0, 1, 8'h03, 0, 0, 8'h80, 8'h03, 8'h02, 8'h24, 0, 0, 0, 0);
        step("R5 cppr 2 precludes direct", 0, 0, 0, 1, 8'h02, 0, 0, 8'h00, 8'h02, 8'h02, 8'h24, 0, 0, 0, 0);
        step("R2 group 1 under cppr 2",    1, 1, 1, 0, 8'h00, 0, 0, 8'hC0, 8'h02, 8'h01, 8'h24, 0, 0, 0, 0);
        step("R5 cppr 1 precludes group",  0, 0, 0, 1, 8'h01, 0, 0, 8'h00, 8'h01, 8'h01, 8'h24, 1, 1, 0, 0);
        step("R4 cppr 6 reposts 2",        0, 0, 0, 1, 8'h06, 0, 0, 8'h80, 8'h06, 8'h02, 8'h24, 0, 0, 0, 0);
        step("R3 group 3 vs pipr not cppr",1, 3, 1, 0, 8'h00, 0, 0, 8'h80, 8'h06, 8'h02, 8'h24, 1, 3, 0, 0);
        step("R6 ack direct 2",            0, 0, 0, 0, 8'h00, 1, 0, 8'h00, 8'h02, 8'h02, 8'h20, 0, 0, 0, 0);
        step("R6 ack with nsr zero",       0, 0, 0, 0, 8'h00, 1, 0, 8'h00, 8'h02, 8'h02, 8'h20, 0, 0, 0, 0);
        step("R4 cppr FF reposts 5",       0, 0, 0, 1, 8'hFF, 0, 0, 8'h80, 8'hFF, 8'h05, 8'h20, 0, 0, 0, 0);
        step("R2 group 4 presented",       1, 4, 1, 0, 8'h00, 0, 0, 8'hC0, 8'hFF, 8'h04, 8'h20, 0, 0, 0, 0);
        step("R7 pull snapshot",           0, 0, 0, 0, 8'h00, 0, 1, 8'h00, 8'hFF, 8'hFF, 8'h00, 1, 4, 1, 32'hC0FF0420);
        step("R7 pull pulse ends",         0, 0, 0, 0, 8'h00, 0, 0, 8'h00, 8'hFF, 8'hFF, 8'h00, 0, 0, 0, 0);
        step("R1 direct 7 after pull",     1, 7, 0, 0, 8'h00, 0, 0, 8'h80, 8'hFF, 8'h07, 8'h80, 0, 0, 0, 0);
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule